// File: doc/BRIEF.md
# Slave-Side Bus Acquisition Controller

This block is the requesting half of a shared external bus for a processor that does not own the bus. Out of reset it leaves every address and control driver floating. It lowers an active-low request to a master and waits for the master's active-low grant. Once the grant has been seen for long enough, it drives the address and control lines at their inactive levels for one cycle. It then runs one access, and hands the bus back by raising the request. One clock edge after that, it floats the drivers again.

Local logic asks for an access with a one-cycle start pulse that carries an address and an access-type flag. Completion is reported with a one-cycle done flag. One job can wait in a holding slot while an access is under way. Memory-type accesses that need a precharge keep the bus until the precharge phase is over. A refresh-enable input is present only so that a setting made in this mode is explicitly ignored: the block never starts a refresh.

The bus pins are modelled as an output-enable plus the level each line would carry when driven. The actual tristate pads sit outside this block.

Top module: `slave_bus_requester`

## Requirements
- R1: While reset is held, bus_oe_o=0, bus_req_n_o=1, bus_ctrl_n_o is all ones and acc_done_o=0. The holding slot leaves reset loaded with the address RST_ADDR as a plain access, so bus_req_n_o falls after the first rising edge after reset, and that first access drives RST_ADDR on bus_addr_o.
- R2: A start pulse sampled while the block is idle with an empty slot makes bus_req_n_o fall after the second rising edge (slot load, then launch). With no job, bus_req_n_o stays high. bus_req_n_o only changes on rising edges.
- R3: The grant pin passes through two flops and must be recognised on two consecutive synchronised samples. If bus_gnt_n_i is low at rising edges k and k+1 while requesting, bus_oe_o goes high after edge k+3. A grant that is low for a single edge never enables the drivers.
- R4: In the first driven cycle (the park cycle), bus_oe_o=1, bus_req_n_o=0, bus_ctrl_n_o is all ones and bus_addr_o carries the job address.
- R5: The access starts on the edge after the park cycle: bus_ctrl_n_o is all zeros for exactly ACC_CYC cycles, and only while bus_oe_o=1 and bus_req_n_o=0.
- R6: When acc_dram_i was 1 for the job, the access is followed by exactly PRE_CYC cycles with the bus driven, controls inactive and the request still low. A plain job (acc_dram_i=0) has none.
- R7: On release, bus_req_n_o rises and acc_done_o is 1 for one cycle. The drivers stay enabled with inactive controls during that cycle, and bus_oe_o is 0 after the next edge.
- R8: If the synchronised grant is high during the park cycle, the block returns to requesting: bus_oe_o=0 and bus_req_n_o=0 after the next edge, and no control strobe is issued.
- R9: A start pulse that arrives while the block is busy is kept in the single slot and launched once the block is idle again. A start is accepted on the same edge the slot is emptied. A start that arrives while the slot is full is dropped.
- R10: refresh_en_i has no effect on any output.
- R11: bus_oe_o is never 1 while bus_req_n_o is 1, except for the single release cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_start_i | input | 1 | One-cycle local access request |
| acc_addr_i | input | AW | Address for the requested access |
| acc_dram_i | input | 1 | 1 = access needs a precharge phase before release |
| refresh_en_i | input | 1 | Refresh enable setting, ignored |
| acc_done_o | output | 1 | One-cycle flag in the release cycle |
| bus_req_n_o | output | 1 | Active-low bus request to the master |
| bus_gnt_n_i | input | 1 | Active-low bus grant from the master, asynchronous |
| bus_oe_o | output | 1 | Enable for the address and control drivers |
| bus_addr_o | output | AW | Address level to drive (zero when not enabled) |
| bus_ctrl_n_o | output | CW | Active-low control strobe levels |

## Verification
Two pairs of events are made to coincide. The first pair is a new local start landing on the same edge as the slot is emptied by a launch. The second pair is the master withdrawing the grant on the very edge the access would begin. Directed sequences place a start one cycle after a launch and a third start while the slot is still full; they then check which addresses appear on the bus and that nothing else follows. A two-cycle grant pulse is sized so that recognition and withdrawal overlap the park cycle, and the bench checks for exactly one driven cycle with no strobe. Random grant lengths and start timing then repeat both collisions many times against a cycle-level reference model.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ASK,
        ST_PARK,
        ST_DRIVE,
        ST_PRECH,
        ST_GIVE
    } sbr_state_e;

endpackage

// File: rtl/sbr_grant_filter.sv
module sbr_grant_filter #(
    parameter int GNT_MIN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gnt_n_i,
    input  logic arm_i,
    output logic held_o,
    output logic ok_o
);
    localparam int RW = $clog2(GNT_MIN + 1);

    typedef struct packed {
        logic          meta;
        logic          held;
        logic [RW-1:0] run;
    } flt_t;

    flt_t flt_d, flt_q;

    always_comb begin
        flt_d      = flt_q;
        flt_d.meta = ~gnt_n_i;
        flt_d.held = flt_q.meta;
        ok_o       = arm_i && flt_q.held && (flt_q.run == RW'(GNT_MIN - 1));
        if (arm_i && flt_q.held && !ok_o) begin
            flt_d.run = flt_q.run + 1'b1;
        end else begin
            flt_d.run = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flt_q <= '0;
        end else begin
            flt_q <= flt_d;
        end
    end

    assign held_o = flt_q.held;

    // R3: recognition needs two consecutive synchronised low samples
    assert_two_samples_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ok_o |-> (flt_q.held && $past(flt_q.held)));

endmodule

// File: rtl/sbr_job_slot.sv
module sbr_job_slot #(
    parameter int            AW       = 32,
    parameter logic [AW-1:0] RST_ADDR = 'hA000_0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW-1:0] addr_i,
    input  logic          dram_i,
    input  logic          take_i,
    output logic          vld_o,
    output logic [AW-1:0] addr_o,
    output logic          dram_o
);
    typedef struct packed {
        logic          vld;
        logic [AW-1:0] addr;
        logic          dram;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (start_i && (!slot_q.vld || take_i)) begin
            slot_d.vld  = 1'b1;
            slot_d.addr = addr_i;
            slot_d.dram = dram_i;
        end else if (take_i) begin
            slot_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q.vld  <= 1'b1;
            slot_q.addr <= RST_ADDR;
            slot_q.dram <= 1'b0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign vld_o  = slot_q.vld;
    assign addr_o = slot_q.addr;
    assign dram_o = slot_q.dram;

    // R9: a start against a full slot that is not being emptied is dropped
    assert_full_slot_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q.vld && start_i && !take_i) |=> (slot_q.addr == $past(slot_q.addr)));

endmodule

// File: rtl/sbr_sequencer.sv
module sbr_sequencer
    import sbr_pkg::*;
#(
    parameter int AW      = 32,
    parameter int CW      = 2,
    parameter int ACC_CYC = 3,
    parameter int PRE_CYC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          job_vld_i,
    input  logic [AW-1:0] job_addr_i,
    input  logic          job_dram_i,
    output logic          take_o,
    input  logic          gnt_ok_i,
    input  logic          gnt_held_i,
    output logic          arm_o,
    output logic          bus_oe_o,
    output logic          bus_req_n_o,
    output logic [AW-1:0] bus_addr_o,
    output logic [CW-1:0] bus_ctrl_n_o,
    output logic          done_o
);
    localparam int TMAX = (ACC_CYC > PRE_CYC) ? ACC_CYC : PRE_CYC;
    localparam int TW   = $clog2(TMAX + 1);

    typedef struct packed {
        sbr_state_e    st;
        logic [TW-1:0] tmr;
        logic [AW-1:0] addr;
        logic          dram;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d  = seq_q;
        take_o = 1'b0;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (job_vld_i) begin
                    take_o     = 1'b1;
                    seq_d.st   = ST_ASK;
                    seq_d.addr = job_addr_i;
                    seq_d.dram = job_dram_i;
                end
            end
            ST_ASK: begin
                if (gnt_ok_i) begin
                    seq_d.st = ST_PARK;
                end
            end
            ST_PARK: begin
                if (!gnt_held_i) begin
                    seq_d.st = ST_ASK;
                end else begin
                    seq_d.st  = ST_DRIVE;
                    seq_d.tmr = TW'(ACC_CYC - 1);
                end
            end
            ST_DRIVE: begin
                if (seq_q.tmr == '0) begin
                    if (seq_q.dram) begin
                        seq_d.st  = ST_PRECH;
                        seq_d.tmr = TW'(PRE_CYC - 1);
                    end else begin
                        seq_d.st = ST_GIVE;
                    end
                end else begin
                    seq_d.tmr = seq_q.tmr - 1'b1;
                end
            end
            ST_PRECH: begin
                if (seq_q.tmr == '0) begin
                    seq_d.st = ST_GIVE;
                end else begin
                    seq_d.tmr = seq_q.tmr - 1'b1;
                end
            end
            ST_GIVE: begin
                seq_d.st = ST_IDLE;
            end
            default: begin
                seq_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.st   <= ST_IDLE;
            seq_q.tmr  <= '0;
            seq_q.addr <= '0;
            seq_q.dram <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    always_comb begin
        arm_o        = (seq_q.st == ST_ASK);
        bus_oe_o     = (seq_q.st == ST_PARK) || (seq_q.st == ST_DRIVE) ||
                       (seq_q.st == ST_PRECH) || (seq_q.st == ST_GIVE);
        bus_req_n_o  = !((seq_q.st == ST_ASK) || (seq_q.st == ST_PARK) ||
                         (seq_q.st == ST_DRIVE) || (seq_q.st == ST_PRECH));
        bus_ctrl_n_o = (seq_q.st == ST_DRIVE) ? '0 : '1;
        bus_addr_o   = bus_oe_o ? seq_q.addr : '0;
        done_o       = (seq_q.st == ST_GIVE);
    end

    // R4: first driven cycle carries inactive controls under an active request
    assert_park_inactive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_oe_o) |-> ((bus_ctrl_n_o == '1) && !bus_req_n_o));

    // R5: strobes only with the bus owned and driven
    assert_strobe_needs_bus_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ctrl_n_o != '1) |-> (bus_oe_o && !bus_req_n_o));

    // R5: the access is preceded by a driven cycle with inactive controls
    assert_park_before_access_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_ctrl_n_o[0]) |-> ($past(bus_oe_o) && ($past(bus_ctrl_n_o) == '1)));

    // R8: grant lost during the park cycle returns to requesting, drivers off
    assert_abort_floats_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((seq_q.st == ST_PARK) && !gnt_held_i) |=> (!bus_oe_o && !bus_req_n_o));

    // R7: drivers float one edge after the request is withdrawn
    assert_float_after_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe_o && bus_req_n_o) |=> !bus_oe_o);

    // R7: the done flag accompanies the release of the request
    assert_done_on_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req_n_o) |-> done_o);

endmodule

// File: rtl/slave_bus_requester.sv
module slave_bus_requester #(
    parameter int            AW       = 32,
    parameter int            CW       = 2,
    parameter int            ACC_CYC  = 3,
    parameter int            PRE_CYC  = 2,
    parameter int            GNT_MIN  = 2,
    parameter logic [AW-1:0] RST_ADDR = 'hA000_0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_start_i,
    input  logic [AW-1:0] acc_addr_i,
    input  logic          acc_dram_i,
    input  logic          refresh_en_i,
    output logic          acc_done_o,
    output logic          bus_req_n_o,
    input  logic          bus_gnt_n_i,
    output logic          bus_oe_o,
    output logic [AW-1:0] bus_addr_o,
    output logic [CW-1:0] bus_ctrl_n_o
);
    logic          job_vld;
    logic [AW-1:0] job_addr;
    logic          job_dram;
    logic          take;
    logic          arm;
    logic          gnt_held;
    logic          gnt_ok;

    // refresh control belongs to the bus owner; the setting is accepted and dropped
    logic unused_refresh;
    assign unused_refresh = refresh_en_i;

    sbr_job_slot #(
        .AW       (AW),
        .RST_ADDR (RST_ADDR)
    ) u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (acc_start_i),
        .addr_i  (acc_addr_i),
        .dram_i  (acc_dram_i),
        .take_i  (take),
        .vld_o   (job_vld),
        .addr_o  (job_addr),
        .dram_o  (job_dram)
    );

    sbr_grant_filter #(
        .GNT_MIN (GNT_MIN)
    ) u_gnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .gnt_n_i (bus_gnt_n_i),
        .arm_i   (arm),
        .held_o  (gnt_held),
        .ok_o    (gnt_ok)
    );

    sbr_sequencer #(
        .AW      (AW),
        .CW      (CW),
        .ACC_CYC (ACC_CYC),
        .PRE_CYC (PRE_CYC)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .job_vld_i    (job_vld),
        .job_addr_i   (job_addr),
        .job_dram_i   (job_dram),
        .take_o       (take),
        .gnt_ok_i     (gnt_ok),
        .gnt_held_i   (gnt_held),
        .arm_o        (arm),
        .bus_oe_o     (bus_oe_o),
        .bus_req_n_o  (bus_req_n_o),
        .bus_addr_o   (bus_addr_o),
        .bus_ctrl_n_o (bus_ctrl_n_o),
        .done_o       (acc_done_o)
    );

    // R1: released state while reset is applied
    assert_reset_released_R1: assert property (@(posedge clk)
        !rst_n |-> (!bus_oe_o && bus_req_n_o && (bus_ctrl_n_o == '1) && !acc_done_o));

    // R11: drivers on with request high only right after the request was withdrawn
    assert_no_drive_when_released_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe_o && bus_req_n_o) |-> $past(!bus_req_n_o));

endmodule

// File: tb/slave_bus_requester_tb.sv
`timescale 1ns/1ps
module slave_bus_requester_tb;
    localparam int            AW   = 32;
    localparam int            CW   = 2;
    localparam int            ACC  = 3;
    localparam int            PRE  = 2;
    localparam int            GMIN = 2;
    localparam logic [AW-1:0] RVEC = 32'hA000_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          acc_start = 1'b0;
    logic [AW-1:0] acc_addr = '0;
    logic          acc_dram = 1'b0;
    logic          refresh_en = 1'b0;
    logic          gnt_n = 1'b1;
    logic          acc_done, req_n, oe;
    logic [AW-1:0] baddr;
    logic [CW-1:0] ctrl_n;

    slave_bus_requester #(
        .AW (AW), .CW (CW), .ACC_CYC (ACC), .PRE_CYC (PRE),
        .GNT_MIN (GMIN), .RST_ADDR (RVEC)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .acc_start_i (acc_start), .acc_addr_i (acc_addr),
        .acc_dram_i (acc_dram), .refresh_en_i (refresh_en), .acc_done_o (acc_done),
        .bus_req_n_o (req_n), .bus_gnt_n_i (gnt_n), .bus_oe_o (oe),
        .bus_addr_o (baddr), .bus_ctrl_n_o (ctrl_n)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // cycle-level reference built from the requirements
    typedef enum int {M_IDLE, M_REQ, M_PARK, M_ACC, M_PRE, M_REL} mst_t;
    mst_t          m_st;
    int            m_tmr, m_run;
    bit            m_s1, m_s2, m_pv, m_pd, m_cd;
    logic [AW-1:0] m_pa, m_ca;
    wire           m_take = (m_st == M_IDLE) && m_pv;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st <= M_IDLE; m_tmr <= 0; m_run <= 0; m_s1 <= 0; m_s2 <= 0;
            m_pv <= 1; m_pa <= RVEC; m_pd <= 0; m_ca <= '0; m_cd <= 0;
        end else begin
            m_s1 <= !gnt_n;
            m_s2 <= m_s1;
            if (acc_start && (!m_pv || m_take)) begin
                m_pv <= 1; m_pa <= acc_addr; m_pd <= acc_dram;
            end else if (m_take) begin
                m_pv <= 0;
            end
            case (m_st)
                M_IDLE: if (m_pv) begin m_st <= M_REQ; m_ca <= m_pa; m_cd <= m_pd; end
                M_REQ: begin
                    if (m_s2) begin
                        if (m_run == GMIN - 1) begin m_st <= M_PARK; m_run <= 0; end
                        else m_run <= m_run + 1;
                    end else m_run <= 0;
                end
                M_PARK: if (!m_s2) m_st <= M_REQ; else begin m_st <= M_ACC; m_tmr <= ACC; end
                M_ACC: begin
                    if (m_tmr == 1) begin
                        if (m_cd) begin m_st <= M_PRE; m_tmr <= PRE; end
                        else m_st <= M_REL;
                    end else m_tmr <= m_tmr - 1;
                end
                M_PRE: if (m_tmr == 1) m_st <= M_REL; else m_tmr <= m_tmr - 1;
                M_REL: m_st <= M_IDLE;
                default: m_st <= M_IDLE;
            endcase
        end
    end

    wire exp_oe = (m_st == M_PARK) || (m_st == M_ACC) || (m_st == M_PRE) || (m_st == M_REL);
    wire exp_rq = !((m_st == M_REQ) || (m_st == M_PARK) || (m_st == M_ACC) || (m_st == M_PRE));
    wire [CW-1:0] exp_ct = (m_st == M_ACC) ? '0 : '1;
    wire [AW-1:0] exp_ad = exp_oe ? m_ca : '0;
    wire exp_dn = (m_st == M_REL);

    bit auto_gnt = 0, rand_start = 0, prev_rel = 0;
    int ghold = 0;

    task automatic tick();
        @(negedge clk);
        acc_start = 1'b0;
        if (rst_n) begin
            chk(oe == exp_oe, "R3 driver enable", oe, exp_oe);
            chk(req_n == exp_rq, "R2 request pin", req_n, exp_rq);
            chk(ctrl_n == exp_ct, "R5 control levels", ctrl_n, exp_ct);
            chk(baddr == exp_ad, "R4 address levels", baddr, exp_ad);
            chk(acc_done == exp_dn, "R7 done flag", acc_done, exp_dn);
            chk(!(oe && req_n && prev_rel), "R11 driven while released", 1, 0);
            prev_rel = oe && req_n;
        end
        if (auto_gnt) begin
            if (ghold > 0) ghold--;
            else if (!req_n && $urandom_range(0, 2) == 0) ghold = $urandom_range(1, 8);
            gnt_n = (ghold > 0) ? 1'b0 : 1'b1;
        end
        if (rand_start && $urandom_range(0, 9) == 0) begin
            acc_start  = 1'b1;
            acc_addr   = $urandom();
            acc_dram   = 1'($urandom_range(0, 1));
            refresh_en = 1'($urandom_range(0, 1));
        end
    endtask

    task automatic start_job(input logic [AW-1:0] a, input bit dr);
        acc_start = 1'b1; acc_addr = a; acc_dram = dr;
    endtask

    task automatic wait_req();
        int n = 0;
        while (req_n && n < 20) begin tick(); n++; end
        chk(!req_n, "R2 request raised", req_n, 0);
    endtask

    int s_lat, s_strb, s_post;
    bit s_park_ok, s_done, s_float;
    logic [AW-1:0] s_addr;

    task automatic serve();
        int n = 0;
        bit seen = 0, strobed = 0;
        s_lat = 0; s_strb = 0; s_post = 0; s_park_ok = 0; s_done = 0; s_float = 0; s_addr = '0;
        gnt_n = 1'b0;
        while (n < 60) begin
            tick(); n++;
            if (oe && !seen) begin
                seen = 1; s_lat = n; s_addr = baddr;
                s_park_ok = (ctrl_n == '1) && !req_n;
            end
            if (ctrl_n == '0) begin s_strb++; strobed = 1; end
            else if (strobed && oe && !req_n) s_post++;
            if (seen && req_n) begin
                s_done = acc_done;
                gnt_n = 1'b1;
                tick();
                s_float = !oe;
                break;
            end
        end
        gnt_n = 1'b1;
    endtask

    initial begin
        #900000;
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int cnt_oe, cnt_strb, cnt_rq;
        void'($urandom(32'd4242));
        repeat (3) tick();
        chk(!oe && req_n && (ctrl_n == '1) && !acc_done, "R1 reset state",
            {oe, req_n, acc_done}, 3'b010);
        rst_n = 1'b1;
        tick();
        chk(!req_n, "R1 reset-vector request", req_n, 0);
        serve();
        chk(s_addr == RVEC, "R1 reset vector address", s_addr, RVEC);
        chk(s_lat == 4, "R3 grant latency", s_lat, 4);
        chk(s_park_ok, "R4 park cycle inactive", s_park_ok, 1);
        chk(s_strb == ACC, "R5 strobe length", s_strb, ACC);
        chk(s_post == 0, "R6 plain job no precharge", s_post, 0);
        chk(s_done, "R7 done at release", s_done, 1);
        chk(s_float, "R7 float after release", s_float, 1);

        // R2: idle stays released, then start-to-request latency
        repeat (3) tick();
        chk(req_n && !oe, "R2 idle released", {req_n, oe}, 2'b10);
        start_job(32'h1234_5678, 0);
        begin
            int n = 0;
            while (req_n && n < 10) begin tick(); n++; end
            chk(n == 2, "R2 start to request", n, 2);
        end
        serve();
        chk(s_addr == 32'h1234_5678, "R4 job address", s_addr, 32'h1234_5678);

        // R6: precharge-type job
        start_job(32'h0000_BEEF, 1);
        wait_req();
        serve();
        chk(s_strb == ACC, "R6 strobe length", s_strb, ACC);
        chk(s_post == PRE, "R6 precharge cycles", s_post, PRE);
        chk(s_done && s_float, "R6 release after precharge", {s_done, s_float}, 2'b11);

        // R3: single-edge grant pulse is not accepted
        start_job(32'h0000_0100, 0);
        wait_req();
        gnt_n = 1'b0; tick(); gnt_n = 1'b1;
        cnt_oe = 0;
        repeat (8) begin tick(); if (oe) cnt_oe++; end
        chk(cnt_oe == 0, "R3 single-cycle grant ignored", cnt_oe, 0);
        serve();
        chk(s_lat == 4 && s_strb == ACC, "R3 access after rejected pulse", s_lat, 4);

        // R8: grant withdrawn during the park cycle
        start_job(32'h0000_0200, 0);
        wait_req();
        gnt_n = 1'b0; tick(); tick(); gnt_n = 1'b1;
        cnt_oe = 0; cnt_strb = 0; cnt_rq = 0;
        repeat (8) begin
            tick();
            if (oe) cnt_oe++;
            if (ctrl_n != '1) cnt_strb++;
            if (req_n) cnt_rq++;
        end
        chk(cnt_oe == 1, "R8 one park cycle then float", cnt_oe, 1);
        chk(cnt_strb == 0, "R8 no strobe after abort", cnt_strb, 0);
        chk(cnt_rq == 0, "R8 still requesting", cnt_rq, 0);
        serve();
        chk(s_addr == 32'h0000_0200, "R8 access completes later", s_addr, 32'h0000_0200);

        // R9: start on the launch edge is held; a third start is dropped
        start_job(32'h0000_0A02, 0); tick();
        start_job(32'h0000_0A03, 0); tick();
        start_job(32'h0000_0A04, 0); tick();
        wait_req();
        serve();
        chk(s_addr == 32'h0000_0A02, "R9 first job", s_addr, 32'h0000_0A02);
        wait_req();
        serve();
        chk(s_addr == 32'h0000_0A03, "R9 held job", s_addr, 32'h0000_0A03);
        cnt_rq = 0;
        repeat (10) begin tick(); if (!req_n) cnt_rq++; end
        chk(cnt_rq == 0, "R9 third start dropped", cnt_rq, 0);

        // R10: refresh enable has no effect
        refresh_en = 1'b1;
        start_job(32'h0000_0C0C, 1);
        wait_req();
        serve();
        chk(s_lat == 4 && s_strb == ACC && s_post == PRE, "R10 timing unchanged", s_strb, ACC);
        chk(s_addr == 32'h0000_0C0C, "R10 address unchanged", s_addr, 32'h0000_0C0C);
        refresh_en = 1'b0;

        // random mix checked against the reference every cycle (R11 included)
        auto_gnt = 1; rand_start = 1;
        repeat (4000) tick();
        rand_start = 0;
        repeat (200) tick();
        auto_gnt = 0; gnt_n = 1'b1;
        repeat (20) tick();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule